// File: doc/BRIEF.md
# DDR SDRAM Refresh Scheduler

This block decides when a DDR SDRAM controller must spend a command slot on an auto-refresh. A free-running interval timer, programmed in clock cycles, adds one to a count of refreshes owed each time it expires. The count can build up to eight, which lets the arbiter delay refreshes while traffic is heavy. The scheduler raises a request whenever a refresh is owed, all banks are precharged and no holdoff is running. Once the count is full it also raises an urgent flag, which tells the arbiter to close its open rows and serve the backlog first.

After every granted refresh the block blocks further commands for the refresh row cycle time. It also handles self-refresh. Entry is accepted only when all banks are idle and no holdoff is running. While the device is in self-refresh the interval timer is frozen and the backlog is dropped. On exit, two separate holdoffs run: a shorter one for non-read commands and a longer one for reads. The arbiter sees the result as two ready flags, one per command class. All timing values are quasi-static inputs in cycles, and the integrator rounds nanosecond values up when converting them.

Top module: `ddr_refresh_sched`

## Requirements
- R1: Outside self-refresh, the owed count rises by one every `cfg_refi` clock cycles, so with prompt grants the rising edges of `ref_req` are exactly `cfg_refi` cycles apart.
- R2: `ref_req` is high only when the owed count is non-zero, `banks_idle` is high and `cmd_ready` is high. After reset it is low, `ref_urgent` is low, and both ready flags are high.
- R3: The owed count saturates at 8. After any long backlog, exactly 8 grants are accepted before `ref_req` stays low. An expiry and a grant in the same cycle leave the count unchanged.
- R4: `ref_urgent` is high exactly when the owed count equals 8 and the block is not in self-refresh, whatever the state of `banks_idle`. At a count of 7 it is low.
- R5: `ref_gnt` is ignored while `ref_req` is low. It neither starts a holdoff nor lowers the owed count below zero.
- R6: After the cycle in which a grant is accepted, `cmd_ready` and `rd_ready` are low for exactly `cfg_rfc` cycles.
- R7: `sr_enter_req` is accepted only when `banks_idle` and `cmd_ready` are high and no grant is being accepted; otherwise it has no effect. `sr_exit_req` has no effect outside self-refresh.
- R8: In self-refresh, `ref_req`, `ref_urgent`, `cmd_ready` and `rd_ready` are low. The owed count is cleared on entry. The interval timer holds its value and resumes from that value on exit.
- R9: After the cycle in which an exit is accepted, `cmd_ready` is low for exactly `cfg_xsnr` cycles and `rd_ready` for exactly `cfg_xsrd` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_refi | input | REFI_W | Refresh interval in cycles |
| cfg_rfc | input | HOLD_W | Refresh row cycle holdoff in cycles |
| cfg_xsnr | input | HOLD_W | Self-refresh exit holdoff for non-read commands, in cycles |
| cfg_xsrd | input | HOLD_W | Self-refresh exit holdoff for reads, in cycles |
| banks_idle | input | 1 | All banks are precharged |
| ref_gnt | input | 1 | Arbiter issues the requested refresh this cycle |
| sr_enter_req | input | 1 | Request to enter self-refresh |
| sr_exit_req | input | 1 | Request to leave self-refresh |
| ref_req | output | 1 | A refresh is owed and may be issued now |
| ref_urgent | output | 1 | Backlog is full; refresh must be served first |
| cmd_ready | output | 1 | Non-read commands may be issued |
| rd_ready | output | 1 | Read commands may be issued |

## Verification
The bench builds a full backlog with the banks busy and checks the urgent flag at counts seven and eight. It then counts the grants accepted while draining. A design that wraps the counter instead of saturating would accept too few or too many refreshes. A stray grant with nothing owed is sent to catch a counter that wraps below zero into a false request. The self-refresh test enters with a refresh still owed and measures the exact cycle of the first request after exit: a timer that ran during self-refresh, a timer restarted on exit, or a backlog kept across entry each moves or adds that request. The refresh and exit holdoffs are measured cycle by cycle, so an off-by-one load or a shared exit timer shows as a wrong window length.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_SELF = 1'b1
  } sched_state_e;
endpackage

// File: rtl/refi_timer.sv
// Interval timer: counts up to period-1, then emits a one-cycle tick and wraps.
module refi_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_end;
  logic             cnt_en;

  assign at_end = (cnt_q == CNT_W'(period - 1'b1));
  assign tick   = at_end && !freeze;
  assign cnt_en = !freeze;

  always_comb begin
    cnt_d = cnt_q;
    if (at_end) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(cnt_q));
  // R1
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/refresh_debt.sv
// Owed-refresh counter, saturating at both ends.
module refresh_debt #(
  parameter int MAX_OWED = 8,
  parameter int OWED_W   = $clog2(MAX_OWED + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              inc,
  input  logic              dec,
  output logic [OWED_W-1:0] owed,
  output logic              at_max
);
  localparam logic [OWED_W-1:0] MAX_V = OWED_W'(MAX_OWED);

  logic [OWED_W-1:0] owed_q, owed_d;

  always_comb begin
    owed_d = owed_q;
    if (clear) begin
      owed_d = '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   if (owed_q != MAX_V) owed_d = owed_q + 1'b1;
        2'b01:   if (owed_q != '0)    owed_d = owed_q - 1'b1;
        default: owed_d = owed_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed_q <= '0;
    else        owed_q <= owed_d;
  end

  assign owed   = owed_q;
  assign at_max = (owed_q == MAX_V);

  // R3
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_q == MAX_V && inc && !dec && !clear) |=> (owed_q == MAX_V));
  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_q == '0 && !inc && !clear) |=> (owed_q == '0));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (owed_q == '0));
endmodule

// File: rtl/hold_timer.sv
// Loadable down-counter; done while it rests at zero.
module hold_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign done   = (cnt_q == '0);
  assign cnt_en = load || !done;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = W'(cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R6
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
  // R9
  count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == W'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/ddr_refresh_sched.sv
module ddr_refresh_sched
  import ref_sched_pkg::*;
#(
  parameter int REFI_W   = 16,
  parameter int HOLD_W   = 8,
  parameter int MAX_OWED = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REFI_W-1:0] cfg_refi,
  input  logic [HOLD_W-1:0] cfg_rfc,
  input  logic [HOLD_W-1:0] cfg_xsnr,
  input  logic [HOLD_W-1:0] cfg_xsrd,
  input  logic              banks_idle,
  input  logic              ref_gnt,
  input  logic              sr_enter_req,
  input  logic              sr_exit_req,
  output logic              ref_req,
  output logic              ref_urgent,
  output logic              cmd_ready,
  output logic              rd_ready
);
  localparam int OWED_W = $clog2(MAX_OWED + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      srst_n     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      srst_n     <= rst_meta_q;
    end
  end

  sched_state_e      state_q, state_d;
  logic              in_self;
  logic              tick;
  logic [OWED_W-1:0] owed;
  logic              at_max;
  logic              rfc_done, xsnr_done, xsrd_done;
  logic              cmd_ok;
  logic              gnt_acc, enter_acc, exit_acc;

  assign in_self = (state_q == ST_SELF);

  refi_timer #(.CNT_W(REFI_W)) u_refi (
    .clk    (clk),
    .rst_n  (srst_n),
    .freeze (in_self),
    .period (cfg_refi),
    .tick   (tick)
  );

  refresh_debt #(.MAX_OWED(MAX_OWED), .OWED_W(OWED_W)) u_debt (
    .clk    (clk),
    .rst_n  (srst_n),
    .clear  (enter_acc),
    .inc    (tick),
    .dec    (gnt_acc),
    .owed   (owed),
    .at_max (at_max)
  );

  hold_timer #(.W(HOLD_W)) u_rfc (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (gnt_acc),
    .load_val (cfg_rfc),
    .done     (rfc_done)
  );

  hold_timer #(.W(HOLD_W)) u_xsnr (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (exit_acc),
    .load_val (cfg_xsnr),
    .done     (xsnr_done)
  );

  hold_timer #(.W(HOLD_W)) u_xsrd (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (exit_acc),
    .load_val (cfg_xsrd),
    .done     (xsrd_done)
  );

  assign cmd_ok    = !in_self && rfc_done && xsnr_done;
  assign ref_req   = cmd_ok && banks_idle && (owed != '0);
  assign gnt_acc   = ref_gnt && ref_req;
  assign enter_acc = !in_self && sr_enter_req && banks_idle && cmd_ok && !gnt_acc;
  assign exit_acc  = in_self && sr_exit_req;

  assign ref_urgent = !in_self && at_max;
  assign cmd_ready  = cmd_ok;
  assign rd_ready   = cmd_ok && xsrd_done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (enter_acc) state_d = ST_SELF;
      ST_SELF: if (exit_acc)  state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  // R6
  rfc_block_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (gnt_acc && cfg_rfc != '0) |=> (!cmd_ready && !rd_ready));
  // R9
  exit_rd_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (exit_acc && cfg_xsrd != '0) |=> !rd_ready);
  // R8
  enter_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    enter_acc |=> (!ref_req && !cmd_ready && !ref_urgent));
  // R4
  urgent_keep_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (ref_urgent && !gnt_acc && !enter_acc) |=> ref_urgent);
endmodule

// File: tb/test_ddr_refresh_sched.sv
module test_ddr_refresh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int REFI = 100;
  localparam int RFC  = 4;
  localparam int XSNR = 12;
  localparam int XSRD = 200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_refi;
  logic [7:0]  cfg_rfc, cfg_xsnr, cfg_xsrd;
  logic        banks_idle, ref_gnt, sr_enter_req, sr_exit_req;
  logic        ref_req, ref_urgent, cmd_ready, rd_ready;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_refresh_sched i_ddr_refresh_sched (
    .clk(clk), .rst_n(rst_n), .cfg_refi(cfg_refi), .cfg_rfc(cfg_rfc),
    .cfg_xsnr(cfg_xsnr), .cfg_xsrd(cfg_xsrd), .banks_idle(banks_idle),
    .ref_gnt(ref_gnt), .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .cmd_ready(cmd_ready),
    .rd_ready(rd_ready)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // wait for ref_req high at a negedge; returns cycles waited
  task automatic wait_req(output int waited);
    waited = 0;
    while (!ref_req && waited < 3 * REFI) begin
      step();
      waited++;
    end
  endtask

  task automatic pulse_gnt();
    ref_gnt = 1'b1;
    step();
    ref_gnt = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; banks_idle = 1'b1; ref_gnt = 1'b0;
    sr_enter_req = 1'b0; sr_exit_req = 1'b0;
    cfg_refi = 16'(REFI); cfg_rfc = 8'(RFC); cfg_xsnr = 8'(XSNR); cfg_xsrd = 8'(XSRD);
    step(3);
    check("R2", "reset ref_req", int'(ref_req), 0);
    check("R2", "reset ref_urgent", int'(ref_urgent), 0);
    check("R2", "reset cmd_ready", int'(cmd_ready), 1);
    check("R2", "reset rd_ready", int'(rd_ready), 1);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic t_interval();
    int w, cnt;
    wait_req(w);
    check("R1", "first request seen", int'(ref_req), 1);
    for (int rep = 0; rep < 2; rep++) begin
      ref_gnt = 1'b1;
      step();
      ref_gnt = 1'b0;
      cnt = 1;
      while (!ref_req && cnt < 1000) begin
        step();
        cnt++;
      end
      check("R1", "cycles between requests", cnt, REFI);
    end
    pulse_gnt();
  endtask

  task automatic t_rfc();
    int w, k;
    wait_req(w);
    ref_gnt = 1'b1;
    step();
    ref_gnt = 1'b0;
    check("R6", "rd_ready right after grant", int'(rd_ready), 0);
    check("R2", "ref_req after debt paid", int'(ref_req), 0);
    k = 0;
    while (!cmd_ready && k < 500) begin
      k++;
      step();
    end
    check("R6", "refresh holdoff length", k, RFC);
    check("R6", "rd_ready after holdoff", int'(rd_ready), 1);
  endtask

  task automatic t_stray_gnt();
    pulse_gnt();
    check("R5", "cmd_ready after stray grant", int'(cmd_ready), 1);
    step(5);
    check("R5", "no request after stray grant", int'(ref_req), 0);
  endtask

  task automatic t_banks_busy();
    int w;
    wait_req(w);
    banks_idle = 1'b0;
    #1;
    check("R2", "ref_req with banks busy", int'(ref_req), 0);
    banks_idle = 1'b1;
    #1;
    check("R2", "ref_req with banks idle", int'(ref_req), 1);
    pulse_gnt();
    step(RFC + 1);
  endtask

  task automatic t_backlog();
    int w, grants, idle;
    wait_req(w);            // owed = 1
    banks_idle = 1'b0;
    step(6 * REFI + 5);     // owed = 7
    check("R4", "urgent at seven owed", int'(ref_urgent), 0);
    step(REFI);             // owed = 8
    check("R4", "urgent at eight owed with banks busy", int'(ref_urgent), 1);
    step(REFI);             // would be 9, saturates
    check("R4", "urgent still high", int'(ref_urgent), 1);
    banks_idle = 1'b1;
    grants = 0;
    forever begin
      idle = 0;
      while (!ref_req && idle < RFC + 3) begin
        step();
        idle++;
      end
      if (!ref_req) break;
      pulse_gnt();
      grants++;
      if (grants == 1) check("R4", "urgent drops after one grant", int'(ref_urgent), 0);
    end
    check("R3", "grants drained from full backlog", grants, 8);
  endtask

  task automatic t_sr_reject();
    banks_idle = 1'b0;
    sr_enter_req = 1'b1;
    step();
    sr_enter_req = 1'b0;
    banks_idle = 1'b1;
    check("R7", "entry refused with banks busy", int'(cmd_ready), 1);
    sr_exit_req = 1'b1;
    step();
    sr_exit_req = 1'b0;
    check("R7", "exit outside self-refresh ignored", int'(rd_ready), 1);
  endtask

  task automatic t_self();
    int w, cmd_low, rd_low, req_low;
    bit seen_req;
    wait_req(w);            // owed = 1, interval counter just wrapped
    sr_enter_req = 1'b1;
    step();
    sr_enter_req = 1'b0;
    check("R8", "cmd_ready in self-refresh", int'(cmd_ready), 0);
    check("R8", "rd_ready in self-refresh", int'(rd_ready), 0);
    seen_req = 1'b0;
    for (int i = 0; i < 3 * REFI; i++) begin
      if (ref_req || ref_urgent) seen_req = 1'b1;
      step();
    end
    check("R8", "no request during self-refresh", int'(seen_req), 0);
    sr_exit_req = 1'b1;
    step();
    sr_exit_req = 1'b0;
    cmd_low = -1; rd_low = -1; req_low = -1;
    for (int k = 0; k < 300; k++) begin
      if (cmd_ready && cmd_low < 0) cmd_low = k;
      if (rd_ready && rd_low < 0) rd_low = k;
      if (ref_req && req_low < 0) begin
        req_low = k;
        ref_gnt = 1'b1;
      end
      step();
      ref_gnt = 1'b0;
    end
    check("R9", "non-read exit holdoff", cmd_low, XSNR);
    check("R9", "read exit holdoff", rd_low, XSRD);
    check("R8", "first request after exit (frozen timer, cleared debt)", req_low, REFI - 1);
  endtask

  initial begin
    t_reset();
    t_interval();
    t_rfc();
    t_stray_gnt();
    t_banks_busy();
    t_backlog();
    t_sr_reject();
    t_self();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule